// File: doc/BRIEF.md
# SDRAM Controller Configuration Register File

This block holds the configuration and status registers of an SDRAM controller. The CPU reaches it through two addresses on a simple control-register bus. One address holds a pointer to an internal register. The other is a data window: a read or write of the window acts on the register that the pointer selects. Behind the pair sit the following registers:

- two sticky error-status registers and an error-address register;
- a master configuration register and a read-only status register;
- refresh, power-management and timing registers;
- one configuration register for each memory bank;
- an ECC configuration register and an ECC error-status register.

The ECC error-status register drives the interrupt output.

Each bus access is a single-cycle strobe with a write-enable. Read data is registered and appears one cycle after the strobe. Writes to the pointer and to most registers take effect at the strobe's clock edge. Several registers apply a write mask or force bits to one, and two registers clear bits when a 1 is written. Changing the enable bits of the configuration register updates status bits as a side effect. The controller logic sets error bits through per-bit set inputs.

Top module: `sdram_cfg_regfile`

## Requirements
- R1: A write to bus address 0x010 loads the internal pointer, and a read of 0x010 returns it. A read of 0x011 returns the register the pointer selects. Read data appears on the output in the cycle after the strobe and holds until the next read. A read of any other bus address returns 0, and a write to any other bus address changes nothing.
- R2: After reset the registers hold these values:
  - pointer: 0;
  - error-status, error-address, bank, ECC config and ECC error-status registers: 0;
  - configuration: 0x00800000;
  - status: 0;
  - refresh: 0x05F00000;
  - power management: 0x07C00000;
  - timing: 0x00854009;
  - interrupt output: low.
- R3: The error-status registers sit at offsets 0x00 and 0x08. A bit is set by a 1 on the matching bit of that register's set input, and stays set. Writing a 1 to a bit through the window clears it. If set and clear hit the same bit in the same cycle, set wins.
- R4: The configuration register sits at offset 0x20 and the status register at 0x24. A configuration write that takes bit 31 from 0 to 1 clears status bit 31. A write that takes bit 31 from 1 to 0 sets status bit 31.
- R5: A configuration write that takes bit 30 from 0 to 1 sets status bit 30. A write that takes bit 30 from 1 to 0 clears status bit 30.
- R6: Writes store only the bits in each register's mask:
  - refresh (offset 0x30): mask 0x3FF80000;
  - timing (offset 0x80): mask 0x018FC01F;
  - ECC configuration (offset 0x94): mask 0x00F00000.
- R7: A write to the power-management register (offset 0x34) stores (value AND 0xF8000000) OR 0x07C00000.
- R8: Writes to the status register (offset 0x24) are ignored.
- R9: The ECC error-status register sits at offset 0x98. The interrupt output rises in the cycle after a write takes that register from zero to nonzero. It falls in the cycle after a write takes it from nonzero to zero.
- R10: A pointer value that selects no register reads as 0 through the window. Writes through the window at such a pointer change no register.
- R11: Full-width writes store the value as written. This applies to the error address (0x10), the configuration register (0x20), the bank registers (0x40, 0x44, 0x48, 0x4C) and the ECC error-status register (0x98).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Single-cycle access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 10 | Bus address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| err0_set_i | input | 32 | Set bits of error-status register 0 |
| err1_set_i | input | 32 | Set bits of error-status register 1 |
| irq_o | output | 1 | ECC error interrupt |

## Verification
The masked registers are written with all-ones and then with all-zeros. This shows whether mask bits are stored and whether forced bits survive a zero write. The configuration register is driven through a sequence of bit-30 and bit-31 transitions, including writes that leave a bit unchanged. This separates edge-triggered status updates from level copies. Error bits are set from the inputs and then cleared with partial masks, which shows which bits a write clears. The ECC error-status register is written zero, nonzero, a different nonzero value and then zero, which separates an interrupt that tracks the nonzero state from one that reacts to every write.

// File: rtl/sdram_cfg_pkg.sv
package sdram_cfg_pkg;
  localparam int DW = 32;

  localparam logic [DW-1:0] OFF_ERR0   = 32'h00;
  localparam logic [DW-1:0] OFF_ERR1   = 32'h08;
  localparam logic [DW-1:0] OFF_EADDR  = 32'h10;
  localparam logic [DW-1:0] OFF_CFG    = 32'h20;
  localparam logic [DW-1:0] OFF_STAT   = 32'h24;
  localparam logic [DW-1:0] OFF_RFSH   = 32'h30;
  localparam logic [DW-1:0] OFF_PM     = 32'h34;
  localparam logic [DW-1:0] OFF_BANK0  = 32'h40;
  localparam logic [DW-1:0] OFF_TIM    = 32'h80;
  localparam logic [DW-1:0] OFF_ECCCFG = 32'h94;
  localparam logic [DW-1:0] OFF_ECCERR = 32'h98;

  localparam logic [DW-1:0] MSK_RFSH   = 32'h3FF8_0000;
  localparam logic [DW-1:0] MSK_TIM    = 32'h018F_C01F;
  localparam logic [DW-1:0] MSK_ECCCFG = 32'h00F0_0000;
  localparam logic [DW-1:0] MSK_PM     = 32'hF800_0000;
  localparam logic [DW-1:0] FRC_PM     = 32'h07C0_0000;

  localparam logic [DW-1:0] RST_CFG  = 32'h0080_0000;
  localparam logic [DW-1:0] RST_RFSH = 32'h05F0_0000;
  localparam logic [DW-1:0] RST_PM   = 32'h07C0_0000;
  localparam logic [DW-1:0] RST_TIM  = 32'h0085_4009;

  localparam int BIT_EN  = 31;
  localparam int BIT_AUX = 30;
endpackage

// File: rtl/sdram_cfg_bus.sv
module sdram_cfg_bus #(
  parameter int          AW       = 10,
  parameter int          DW       = 32,
  parameter logic [9:0]  PTR_ADDR = 10'h010,
  parameter logic [9:0]  WIN_ADDR = 10'h011
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] win_rdata_i,
  output logic [DW-1:0] ptr_o,
  output logic          win_wr_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] ptr_q, rdata_q;
  logic hit_ptr, hit_win, rd_stb;

  assign hit_ptr  = (addr_i == AW'(PTR_ADDR));
  assign hit_win  = (addr_i == AW'(WIN_ADDR));
  assign rd_stb   = valid_i && !we_i;
  assign win_wr_o = valid_i && we_i && hit_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (valid_i && we_i && hit_ptr) ptr_q <= wdata_i;
      if (rd_stb) begin
        if (hit_ptr)      rdata_q <= ptr_q;
        else if (hit_win) rdata_q <= win_rdata_i;
        else              rdata_q <= '0;
      end
    end
  end

  assign ptr_o   = ptr_q;
  assign rdata_o = rdata_q;

  // R1: read data only moves after a read strobe
  a_r1_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_stb |=> $stable(rdata_q));
  // R1: pointer only moves on a pointer write
  a_r1_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && we_i && hit_ptr) |=> $stable(ptr_q));
endmodule

// File: rtl/sdram_cfg_ecc_irq.sv
module sdram_cfg_ecc_irq #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ecc_err_o,
  output logic          irq_o
);
  logic [DW-1:0] ecc_err_q;
  logic          irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ecc_err_q <= '0;
      irq_q     <= 1'b0;
    end else if (wr_i) begin
      ecc_err_q <= wdata_i;
      if (ecc_err_q == '0 && wdata_i != '0)      irq_q <= 1'b1;
      else if (ecc_err_q != '0 && wdata_i == '0) irq_q <= 1'b0;
    end
  end

  assign ecc_err_o = ecc_err_q;
  assign irq_o     = irq_q;

  // R9: a rising interrupt needs a nonzero write
  a_r9_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(wr_i && wdata_i != '0));
  // R9: a falling interrupt needs a zero write
  a_r9_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_q) |-> $past(wr_i && wdata_i == '0));
endmodule

// File: rtl/sdram_cfg_regs.sv
module sdram_cfg_regs
  import sdram_cfg_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] ptr_i,
  input  logic          win_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] err0_set_i,
  input  logic [DW-1:0] err1_set_i,
  input  logic [DW-1:0] ecc_err_i,
  output logic          ecc_wr_o,
  output logic [DW-1:0] rdata_o
);
  localparam int BANK_STRIDE = 4;

  logic [DW-1:0] err0_q, err1_q, eaddr_q, cfg_q, stat_q;
  logic [DW-1:0] rfsh_q, pm_q, tim_q, ecccfg_q;
  logic [DW-1:0] bank_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_hit;

  logic wr_err0, wr_err1, wr_cfg;
  assign wr_err0  = win_wr_i && ptr_i == OFF_ERR0;
  assign wr_err1  = win_wr_i && ptr_i == OFF_ERR1;
  assign wr_cfg   = win_wr_i && ptr_i == OFF_CFG;
  assign ecc_wr_o = win_wr_i && ptr_i == OFF_ECCERR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err0_q <= '0;
      err1_q <= '0;
    end else begin
      err0_q <= (err0_q & ~(wr_err0 ? wdata_i : '0)) | err0_set_i;
      err1_q <= (err1_q & ~(wr_err1 ? wdata_i : '0)) | err1_set_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= RST_CFG;
      stat_q <= '0;
    end else if (wr_cfg) begin
      cfg_q <= wdata_i;
      if (!cfg_q[BIT_EN] && wdata_i[BIT_EN])      stat_q[BIT_EN] <= 1'b0;
      else if (cfg_q[BIT_EN] && !wdata_i[BIT_EN]) stat_q[BIT_EN] <= 1'b1;
      if (!cfg_q[BIT_AUX] && wdata_i[BIT_AUX])      stat_q[BIT_AUX] <= 1'b1;
      else if (cfg_q[BIT_AUX] && !wdata_i[BIT_AUX]) stat_q[BIT_AUX] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eaddr_q  <= '0;
      rfsh_q   <= RST_RFSH;
      pm_q     <= RST_PM;
      tim_q    <= RST_TIM;
      ecccfg_q <= '0;
    end else if (win_wr_i) begin
      case (ptr_i)
        OFF_EADDR:  eaddr_q  <= wdata_i;
        OFF_RFSH:   rfsh_q   <= wdata_i & MSK_RFSH;
        OFF_PM:     pm_q     <= (wdata_i & MSK_PM) | FRC_PM;
        OFF_TIM:    tim_q    <= wdata_i & MSK_TIM;
        OFF_ECCCFG: ecccfg_q <= wdata_i & MSK_ECCCFG;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    assign bank_hit[i] = (ptr_i == OFF_BANK0 + DW'(BANK_STRIDE * i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     bank_q[i] <= '0;
      else if (win_wr_i && bank_hit[i]) bank_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (ptr_i)
      OFF_ERR0:   rdata_o = err0_q;
      OFF_ERR1:   rdata_o = err1_q;
      OFF_EADDR:  rdata_o = eaddr_q;
      OFF_CFG:    rdata_o = cfg_q;
      OFF_STAT:   rdata_o = stat_q;
      OFF_RFSH:   rdata_o = rfsh_q;
      OFF_PM:     rdata_o = pm_q;
      OFF_TIM:    rdata_o = tim_q;
      OFF_ECCCFG: rdata_o = ecccfg_q;
      OFF_ECCERR: rdata_o = ecc_err_i;
      default: ;
    endcase
    for (int i = 0; i < NUM_BANKS; i++)
      if (bank_hit[i]) rdata_o = bank_q[i];
  end

  // R8: status moves only on a config write
  a_r8_status_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg |=> $stable(stat_q));
  // R4: enabling clears status bit 31
  a_r4_enable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && !cfg_q[BIT_EN] && wdata_i[BIT_EN]) |=> !stat_q[BIT_EN]);
  // R5: bit 30 rising sets status bit 30
  a_r5_aux_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && !cfg_q[BIT_AUX] && wdata_i[BIT_AUX]) |=> stat_q[BIT_AUX]);
  // R3: set input always lands
  a_r3_set_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err0_set_i != '0) |=> ((err0_q & $past(err0_set_i)) == $past(err0_set_i)));
  // R7: forced field never reads as zero
  a_r7_pm_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_q & FRC_PM) == FRC_PM);
  // R6: refresh holds no bit outside its mask
  a_r6_rfsh_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_q & ~MSK_RFSH) == '0);
endmodule

// File: rtl/sdram_cfg_regfile.sv
module sdram_cfg_regfile
  import sdram_cfg_pkg::*;
#(
  parameter int         BUS_AW    = 10,
  parameter int         NUM_BANKS = 4,
  parameter logic [9:0] PTR_ADDR  = 10'h010,
  parameter logic [9:0] WIN_ADDR  = 10'h011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic [DW-1:0]     err0_set_i,
  input  logic [DW-1:0]     err1_set_i,
  output logic              irq_o
);
  logic [DW-1:0] ptr, win_rdata, ecc_err;
  logic          win_wr, ecc_wr;

  sdram_cfg_bus #(
    .AW(BUS_AW), .DW(DW), .PTR_ADDR(PTR_ADDR), .WIN_ADDR(WIN_ADDR)
  ) u_bus (
    .clk_i, .rst_ni,
    .valid_i     (bus_valid_i),
    .we_i        (bus_we_i),
    .addr_i      (bus_addr_i),
    .wdata_i     (bus_wdata_i),
    .win_rdata_i (win_rdata),
    .ptr_o       (ptr),
    .win_wr_o    (win_wr),
    .rdata_o     (bus_rdata_o)
  );

  sdram_cfg_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk_i, .rst_ni,
    .ptr_i      (ptr),
    .win_wr_i   (win_wr),
    .wdata_i    (bus_wdata_i),
    .err0_set_i (err0_set_i),
    .err1_set_i (err1_set_i),
    .ecc_err_i  (ecc_err),
    .ecc_wr_o   (ecc_wr),
    .rdata_o    (win_rdata)
  );

  sdram_cfg_ecc_irq #(.DW(DW)) u_ecc (
    .clk_i, .rst_ni,
    .wr_i      (ecc_wr),
    .wdata_i   (bus_wdata_i),
    .ecc_err_o (ecc_err),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/sdram_cfg_regfile_tb.sv
module sdram_cfg_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        valid = 0, we = 0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, set0 = '0, set1 = '0;
  logic        irq;
  int          n_run = 0, n_fail = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cfg_regfile u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .err0_set_i(set0), .err1_set_i(set1), .irq_o(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); valid = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; we = 0;
  endtask

  task automatic bus_rd(logic [9:0] a, output logic [31:0] d);
    @(negedge clk); valid = 1; we = 0; addr = a;
    @(negedge clk); valid = 0; d = rdata;
  endtask

  task automatic reg_wr(logic [31:0] off, logic [31:0] d);
    bus_wr(10'h010, off); bus_wr(10'h011, d);
  endtask

  task automatic reg_rd(logic [31:0] off, output logic [31:0] d);
    bus_wr(10'h010, off); bus_rd(10'h011, d);
  endtask

  task automatic t_reset;
    check("R2 irq", {31'b0, irq}, 32'h0);
    bus_rd(10'h010, rv); check("R2 ptr", rv, 32'h0);
    reg_rd(32'h00, rv); check("R2 err0", rv, 32'h0);
    reg_rd(32'h08, rv); check("R2 err1", rv, 32'h0);
    reg_rd(32'h10, rv); check("R2 eaddr", rv, 32'h0);
    reg_rd(32'h20, rv); check("R2 cfg", rv, 32'h0080_0000);
    reg_rd(32'h24, rv); check("R2 stat", rv, 32'h0);
    reg_rd(32'h30, rv); check("R2 rfsh", rv, 32'h05F0_0000);
    reg_rd(32'h34, rv); check("R2 pm", rv, 32'h07C0_0000);
    reg_rd(32'h80, rv); check("R2 tim", rv, 32'h0085_4009);
    reg_rd(32'h94, rv); check("R2 ecccfg", rv, 32'h0);
    reg_rd(32'h98, rv); check("R2 eccerr", rv, 32'h0);
    for (int i = 0; i < 4; i++) begin
      reg_rd(32'h40 + 4*i, rv); check("R2 bank", rv, 32'h0);
    end
  endtask

  task automatic t_pointer;
    bus_wr(10'h010, 32'h0000_0123);
    bus_rd(10'h010, rv); check("R1 ptr readback", rv, 32'h0000_0123);
    // read latency: data one cycle after strobe, then held
    reg_wr(32'h10, 32'hA5A5_0001);
    @(negedge clk); valid = 1; we = 0; addr = 10'h011;
    @(negedge clk); valid = 0;
    check("R1 latency", rdata, 32'hA5A5_0001);
    @(negedge clk); check("R1 hold", rdata, 32'hA5A5_0001);
    bus_rd(10'h012, rv); check("R1 other addr reads 0", rv, 32'h0);
    bus_wr(10'h012, 32'h0000_0030);
    bus_rd(10'h010, rv); check("R1 other addr write ignored", rv, 32'h10);
  endtask

  task automatic t_masks;
    reg_wr(32'h30, 32'hFFFF_FFFF); reg_rd(32'h30, rv); check("R6 rfsh", rv, 32'h3FF8_0000);
    reg_wr(32'h80, 32'hFFFF_FFFF); reg_rd(32'h80, rv); check("R6 tim", rv, 32'h018F_C01F);
    reg_wr(32'h94, 32'hFFFF_FFFF); reg_rd(32'h94, rv); check("R6 ecccfg", rv, 32'h00F0_0000);
    reg_wr(32'h34, 32'h0000_0000); reg_rd(32'h34, rv); check("R7 pm zero", rv, 32'h07C0_0000);
    reg_wr(32'h34, 32'hFFFF_FFFF); reg_rd(32'h34, rv); check("R7 pm ones", rv, 32'hFFC0_0000);
  endtask

  task automatic t_cfg_status;
    reg_wr(32'h20, 32'h4000_0000); reg_rd(32'h24, rv); check("R5 aux rise", rv, 32'h4000_0000);
    reg_wr(32'h20, 32'h4000_0000); reg_rd(32'h24, rv); check("R5 aux steady", rv, 32'h4000_0000);
    reg_wr(32'h20, 32'h8000_0000); reg_rd(32'h24, rv); check("R5 aux fall", rv, 32'h0);
    reg_wr(32'h20, 32'h0000_0000); reg_rd(32'h24, rv); check("R4 en fall", rv, 32'h8000_0000);
    reg_wr(32'h20, 32'h0000_0000); reg_rd(32'h24, rv); check("R4 en steady", rv, 32'h8000_0000);
    reg_wr(32'h20, 32'hC000_0000); reg_rd(32'h24, rv); check("R4 en rise", rv, 32'h4000_0000);
    reg_rd(32'h20, rv); check("R11 cfg stored", rv, 32'hC000_0000);
  endtask

  task automatic t_status_ro;
    reg_wr(32'h24, 32'hFFFF_FFFF); reg_rd(32'h24, rv); check("R8 status ro", rv, 32'h4000_0000);
    reg_wr(32'h24, 32'h0000_0000); reg_rd(32'h24, rv); check("R8 status ro zero", rv, 32'h4000_0000);
  endtask

  task automatic t_w1c;
    @(negedge clk); set0 = 32'h0000_00F3; set1 = 32'h8000_0001;
    @(negedge clk); set0 = '0; set1 = '0;
    reg_rd(32'h00, rv); check("R3 err0 set", rv, 32'h0000_00F3);
    reg_rd(32'h08, rv); check("R3 err1 set", rv, 32'h8000_0001);
    reg_wr(32'h00, 32'h0000_0003); reg_rd(32'h00, rv); check("R3 err0 clr", rv, 32'h0000_00F0);
    reg_wr(32'h08, 32'h0000_0001); reg_rd(32'h08, rv); check("R3 err1 clr", rv, 32'h8000_0000);
    // set and clear on the same bit in the same cycle: set wins
    bus_wr(10'h010, 32'h00);
    @(negedge clk); valid = 1; we = 1; addr = 10'h011; wdata = 32'h0000_0010; set0 = 32'h0000_0010;
    @(negedge clk); valid = 0; we = 0; set0 = '0;
    reg_rd(32'h00, rv); check("R3 set wins", rv, 32'h0000_00F0);
  endtask

  task automatic t_irq;
    reg_wr(32'h98, 32'h0); check("R9 zero write no irq", {31'b0, irq}, 32'h0);
    bus_wr(10'h010, 32'h98);
    @(negedge clk); valid = 1; we = 1; addr = 10'h011; wdata = 32'h0000_0004;
    @(negedge clk); valid = 0; we = 0;
    check("R9 irq rises next cycle", {31'b0, irq}, 32'h1);
    reg_wr(32'h98, 32'h0000_0100); check("R9 irq stays", {31'b0, irq}, 32'h1);
    reg_rd(32'h98, rv); check("R11 eccerr stored", rv, 32'h0000_0100);
    reg_wr(32'h98, 32'h0); check("R9 irq falls", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_unmapped;
    reg_wr(32'h00, 32'hFFFF_FFFF); // clear err0
    reg_wr(32'h04, 32'hDEAD_BEEF); reg_rd(32'h04, rv); check("R10 unmapped reads 0", rv, 32'h0);
    reg_rd(32'h00, rv); check("R10 neighbour untouched", rv, 32'h0);
    reg_rd(32'h10, rv); check("R10 eaddr untouched", rv, 32'hA5A5_0001);
    reg_wr(32'h50, 32'h1234_5678); reg_rd(32'h50, rv); check("R10 past banks reads 0", rv, 32'h0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 4; i++) reg_wr(32'h40 + 4*i, 32'h1111_0000 * (i + 1) + i);
    for (int i = 0; i < 4; i++) begin
      reg_rd(32'h40 + 4*i, rv); check("R11 bank", rv, 32'h1111_0000 * (i + 1) + i);
    end
    reg_wr(32'h10, 32'hFFFF_FFFF); reg_rd(32'h10, rv); check("R11 eaddr", rv, 32'hFFFF_FFFF);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_pointer;
    t_masks;
    t_cfg_status;
    t_status_ro;
    t_w1c;
    t_irq;
    t_unmapped;
    t_full;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule